// File: doc/BRIEF.md
# Bus Ownership Mailbox Behind an Index/Data Window

This block models the part of an embedded microcontroller that a host uses to take and give back ownership of a shared SMBus. The host reaches the block through a window of two byte ports. The index port selects an internal register. The data port then reads or writes the selected register. Reads are combinational, so the read data always shows the register that the current index selects.

Three registers form a command mailbox: a response register, an ownership argument register and a command register. To run a command, the host clears the response register, writes an argument, and then writes a command code. A responder model waits a fixed, parameterised number of cycles. It then grants or releases ownership and posts a completion code, which the host polls for. The output `host_owns_bus` tells the SMBus logic whether the host currently holds the bus.

Top module: `own_mailbox_window`

## Requirements
- R1: After reset, the index register, the command register (index 0x80), the response register (index 0x82) and the argument register (index 0x83) all read 0x00, and `host_owns_bus` is 0.
- R2: A write with `win_sel`=0 loads `win_wdata` into the index register. With `win_sel`=0, `win_rdata` shows the index register.
- R3: With `win_sel`=1, `win_rdata` shows the register selected by the index. A write with `win_sel`=1 stores `win_wdata` into that register. The mapped indices are 0x80 (command), 0x82 (response) and 0x83 (argument).
- R4: With `win_sel`=1, any index other than 0x80, 0x82 or 0x83 reads 0x00. A write to such an index changes no register and does not change `host_owns_bus`.
- R5: The host can overwrite the response register, including clearing it with 0x00, whenever no completion happens in the same cycle.
- R6: A write to the command register starts the responder. `host_owns_bus` and the response register change exactly LATENCY clock edges after the edge that captured the command write. They do not change before that edge.
- R7: Command 0x96 with argument 0xB4 sets `host_owns_bus` to 1 and posts 0xFA to the response register.
- R8: Command 0x96 with argument 0xB5 sets `host_owns_bus` to 0 and posts 0xFA to the response register.
- R9: Any other command code, or any other argument value with 0x96, leaves `host_owns_bus` unchanged and posts 0xEE to the response register.
- R10: The responder uses the argument held at the moment the command is written. Argument writes made while the command is pending do not affect the outcome, but they are still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_sel | input | 1 | Port select: 0 = index port, 1 = data port |
| win_we | input | 1 | Write strobe for the selected port |
| win_wdata | input | 8 | Write data |
| win_rdata | output | 8 | Read data of the selected port |
| host_owns_bus | output | 1 | 1 while the host owns the SMBus |

## Verification
The bench builds the block with LATENCY=5. This value is short enough that every one of the 256 argument values and every one of the 256 command codes can run a full command cycle within a few thousand cycles. It is also long enough that the cycle-exact timing check can see an argument rewritten while a command is pending. The bench also sweeps all 256 indices through the data port, both reading and writing. This confirms that only the three mailbox indices decode.

// File: rtl/own_mailbox_pkg.sv
// Package: mailbox index map and code values shared by the window logic.
// Assumes byte-wide registers; the values are fixed by the host protocol.
package own_mailbox_pkg;
    localparam int          BYTE_W     = 8;
    localparam logic [7:0]  IDX_CMD    = 8'h80;
    localparam logic [7:0]  IDX_RESP   = 8'h82;
    localparam logic [7:0]  IDX_ARG    = 8'h83;
    localparam logic [7:0]  CMD_OWNER  = 8'h96;
    localparam logic [7:0]  ARG_TAKE   = 8'hB4;
    localparam logic [7:0]  ARG_GIVE   = 8'hB5;
    localparam logic [7:0]  RESP_DONE  = 8'hFA;
    localparam logic [7:0]  RESP_ERROR = 8'hEE;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_RESP = 2'd2,
        SEL_ARG  = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/own_mailbox_regs.sv
// Module: index/data window decode. Holds the index, command and argument
// registers, forwards response writes and command strobes to the responder,
// and multiplexes read data. Assumes one access per cycle.
module own_mailbox_regs
    import own_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_sel,
    input  logic              win_we,
    input  logic [BYTE_W-1:0] win_wdata,
    input  logic [BYTE_W-1:0] resp_val,
    output logic [BYTE_W-1:0] win_rdata,
    output logic [BYTE_W-1:0] arg_val,
    output logic              cmd_start,
    output logic              resp_wr
);
    logic [BYTE_W-1:0] index_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] arg_q;
    reg_sel_t          sel;
    logic              data_wr;

    // Decode the current index into a mailbox register selection.
    always_comb begin
        unique case (index_q)
            IDX_CMD:  sel = SEL_CMD;
            IDX_RESP: sel = SEL_RESP;
            IDX_ARG:  sel = SEL_ARG;
            default:  sel = SEL_NONE;
        endcase
    end

    assign data_wr   = win_we && win_sel;
    assign cmd_start = data_wr && (sel == SEL_CMD);
    assign resp_wr   = data_wr && (sel == SEL_RESP);
    assign arg_val   = arg_q;

    // Index, command and argument registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            cmd_q   <= '0;
            arg_q   <= '0;
        end else begin
            if (win_we && !win_sel) index_q <= win_wdata;
            if (cmd_start)          cmd_q   <= win_wdata;
            if (data_wr && sel == SEL_ARG) arg_q <= win_wdata;
        end
    end

    // Read multiplexer: index port or selected mailbox register.
    always_comb begin
        if (!win_sel) begin
            win_rdata = index_q;
        end else begin
            unique case (sel)
                SEL_CMD:  win_rdata = cmd_q;
                SEL_RESP: win_rdata = resp_val;
                SEL_ARG:  win_rdata = arg_q;
                default:  win_rdata = '0;
            endcase
        end
    end

    AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel == SEL_NONE) |=> ($stable(cmd_q) && $stable(arg_q))); // R4
    AST_INDEX_PORT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && !win_sel) |=> (index_q == $past(win_wdata))); // R2
endmodule

// File: rtl/own_mailbox_responder.sv
// Module: fixed-latency responder. Captures the command and argument on a
// command write, counts LATENCY edges, then updates ownership and posts a
// completion or error code. A new command while pending restarts the count.
// Assumes LATENCY >= 1.
module own_mailbox_responder
    import own_mailbox_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic [BYTE_W-1:0] arg_val,
    input  logic              resp_wr,
    input  logic [BYTE_W-1:0] resp_wdata,
    output logic [BYTE_W-1:0] resp_val,
    output logic              owns
);
    localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY);

    logic              busy_q;
    logic [CW-1:0]     cnt_q;
    logic [BYTE_W-1:0] cmd_l;
    logic [BYTE_W-1:0] arg_l;
    logic              finish;
    logic              valid_req;

    assign finish    = busy_q && (cnt_q == '0) && !cmd_start;
    assign valid_req = (cmd_l == CMD_OWNER) &&
                       ((arg_l == ARG_TAKE) || (arg_l == ARG_GIVE));

    // Pending-command tracking and latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cmd_l  <= '0;
            arg_l  <= '0;
        end else if (cmd_start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(LATENCY - 1);
            cmd_l  <= cmd_code;
            arg_l  <= arg_val;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Response register and ownership flag; completion beats host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_val <= '0;
            owns     <= 1'b0;
        end else if (finish) begin
            if (valid_req) begin
                owns     <= (arg_l == ARG_TAKE);
                resp_val <= RESP_DONE;
            end else begin
                resp_val <= RESP_ERROR;
            end
        end else if (resp_wr) begin
            resp_val <= resp_wdata;
        end
    end

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> busy_q); // R6
    AST_OWN_ONLY_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(owns)); // R6
    AST_TAKE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && cmd_l == CMD_OWNER && arg_l == ARG_TAKE) |=> (owns && resp_val == RESP_DONE)); // R7
    AST_GIVE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && cmd_l == CMD_OWNER && arg_l == ARG_GIVE) |=> (!owns && resp_val == RESP_DONE)); // R8
    AST_BAD_REQ_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !valid_req) |=> (resp_val == RESP_ERROR && $stable(owns))); // R9
endmodule

// File: rtl/own_mailbox_window.sv
// Module: top of the ownership mailbox. Connects the index/data window
// decode to the fixed-latency responder and exports the ownership flag.
// Assumes a single host and synchronous active-low reset.
module own_mailbox_window
    import own_mailbox_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_sel,
    input  logic       win_we,
    input  logic [7:0] win_wdata,
    output logic [7:0] win_rdata,
    output logic       host_owns_bus
);
    logic [BYTE_W-1:0] resp_val;
    logic [BYTE_W-1:0] arg_val;
    logic              cmd_start;
    logic              resp_wr;

    own_mailbox_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_sel   (win_sel),
        .win_we    (win_we),
        .win_wdata (win_wdata),
        .resp_val  (resp_val),
        .win_rdata (win_rdata),
        .arg_val   (arg_val),
        .cmd_start (cmd_start),
        .resp_wr   (resp_wr)
    );

    own_mailbox_responder #(.LATENCY(LATENCY)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_code   (win_wdata),
        .arg_val    (arg_val),
        .resp_wr    (resp_wr),
        .resp_wdata (win_wdata),
        .resp_val   (resp_val),
        .owns       (host_owns_bus)
    );
endmodule

// File: tb/tb_own_mailbox_window.sv
module tb_own_mailbox_window;
    localparam int LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_sel = 1'b0;
    logic       win_we = 1'b0;
    logic [7:0] win_wdata = '0;
    logic [7:0] win_rdata;
    logic       host_owns_bus;

    int checks = 0;
    int errors = 0;
    logic exp_own = 1'b0;

    always #2.5 clk = ~clk;

    own_mailbox_window #(.LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .win_we(win_we),
        .win_wdata(win_wdata), .win_rdata(win_rdata), .host_owns_bus(host_owns_bus)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        win_sel = sel; win_we = 1'b1; win_wdata = d;
        @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic put(input logic [7:0] idx, input logic [7:0] d);
        wr(1'b0, idx);
        wr(1'b1, d);
    endtask

    task automatic get(input logic [7:0] idx, output logic [7:0] v);
        wr(1'b0, idx);
        win_sel = 1'b1;
        #1 v = win_rdata;
    endtask

    // Full command cycle; returns the polled response.
    task automatic run_cmd(input logic [7:0] code, input logic [7:0] arg, output logic [7:0] r);
        put(8'h82, 8'h00);
        put(8'h83, arg);
        put(8'h80, code);
        repeat (LAT + 1) @(negedge clk);
        get(8'h82, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h01, 8'h00);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        win_sel = 1'b0; #1;
        check("R1 index", win_rdata, 8'h00);
        check("R1 owns", {7'd0, host_owns_bus}, 8'h00);
        get(8'h80, v); check("R1 cmd", v, 8'h00);
        get(8'h82, v); check("R1 resp", v, 8'h00);
        get(8'h83, v); check("R1 arg", v, 8'h00);

        // R2 index port
        wr(1'b0, 8'h37); win_sel = 1'b0; #1;
        check("R2 index readback", win_rdata, 8'h37);

        // R3 and R5 mapped read/write
        put(8'h83, 8'h5C); get(8'h83, v); check("R3 arg rw", v, 8'h5C);
        put(8'h82, 8'hA7); get(8'h82, v); check("R5 resp write", v, 8'hA7);
        put(8'h82, 8'h00); get(8'h82, v); check("R5 resp clear", v, 8'h00);

        // R6 exact latency via ownership output
        put(8'h82, 8'h00);
        put(8'h83, 8'hB4);
        put(8'h80, 8'h96);
        repeat (LAT - 1) @(negedge clk);
        check("R6 not yet", {7'd0, host_owns_bus}, 8'h00);
        @(negedge clk);
        check("R6 on time", {7'd0, host_owns_bus}, 8'h01);
        exp_own = 1'b1;
        get(8'h82, v); check("R7 resp done", v, 8'hFA);
        get(8'h80, v); check("R3 cmd readback", v, 8'h96);

        // R8 release
        run_cmd(8'h96, 8'hB5, v);
        check("R8 resp", v, 8'hFA);
        check("R8 owns", {7'd0, host_owns_bus}, 8'h00);
        exp_own = 1'b0;

        // R10 argument captured at command write
        put(8'h82, 8'h00);
        put(8'h83, 8'hB4);
        put(8'h80, 8'h96);
        put(8'h83, 8'hB5);
        repeat (LAT + 1) @(negedge clk);
        check("R10 owns uses captured arg", {7'd0, host_owns_bus}, 8'h01);
        exp_own = 1'b1;
        get(8'h83, v); check("R10 arg still stored", v, 8'hB5);

        // R7 R8 R9 argument sweep with command 0x96
        for (int a = 0; a < 256; a++) begin
            run_cmd(8'h96, 8'(a), v);
            if (a == 8'hB4 || a == 8'hB5) begin
                e = 8'hFA;
                exp_own = (a == 8'hB4);
            end else begin
                e = 8'hEE;
            end
            check("R9 arg sweep resp", v, e);
            check("R9 arg sweep owns", {7'd0, host_owns_bus}, {7'd0, exp_own});
        end

        // R9 command sweep with alternating valid arguments
        for (int c = 0; c < 256; c++) begin
            logic [7:0] ar;
            ar = c[0] ? 8'hB5 : 8'hB4;
            run_cmd(8'(c), ar, v);
            if (c == 8'h96) begin
                e = 8'hFA;
                exp_own = (ar == 8'hB4);
            end else begin
                e = 8'hEE;
            end
            check("R9 cmd sweep resp", v, e);
            check("R9 cmd sweep owns", {7'd0, host_owns_bus}, {7'd0, exp_own});
        end

        // R4 unmapped index sweep
        put(8'h83, 8'h3C);
        put(8'h80, 8'h11);
        repeat (LAT + 1) @(negedge clk);
        put(8'h82, 8'h44);
        for (int i = 0; i < 256; i++) begin
            if (i != 8'h80 && i != 8'h82 && i != 8'h83) begin
                put(8'(i), 8'hA5);
                win_sel = 1'b1; #1;
                check("R4 unmapped read", win_rdata, 8'h00);
            end
        end
        get(8'h83, v); check("R4 arg untouched", v, 8'h3C);
        get(8'h80, v); check("R4 cmd untouched", v, 8'h11);
        get(8'h82, v); check("R4 resp untouched", v, 8'h44);
        check("R4 owns untouched", {7'd0, host_owns_bus}, {7'd0, exp_own});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule